// File: doc/BRIEF.md
# Debug Breakpoint Generation Unit

This unit sits between the debug comparators and the processor's exception logic. Four watchpoint hit lines come in from comparators outside the block. Each hit is copied to a dedicated watchpoint pin, and that copy never changes execution. Each watchpoint is armed by a software trap enable, a development-port trap enable, or both. It also has a programmable occurrence count, so it can raise a breakpoint on every hit or only on every Nth hit.

Three external request lines carry breakpoint requests from on-chip peripherals, off-chip peripherals and an external debug tool. All sources are gathered into a pending cause vector. Whether a breakpoint is recognised depends on the machine-restartable status input, unless the mask-mode control is off. The request to the exception logic is a registered level. It stays up until the exception logic acknowledges it.

Top module: `dbg_brk_unit`

## Requirements
- R1: `wp_pin_o[i]` equals `wp_hit_i[i]` one clock later. A hit on a watchpoint whose two trap enables are both clear raises no request and sets no cause bit.
- R2: A watchpoint is armed when its software trap enable or its development-port trap enable is set. Either enable alone is enough to raise a breakpoint.
- R3: An armed watchpoint with a count of 0 or 1 raises a breakpoint on every hit.
- R4: An armed watchpoint with a count N > 1 raises a breakpoint on the Nth hit after it was configured. Its counter then reloads, and the next breakpoint comes after another N hits.
- R5: A configuration write to a watchpoint reloads its counter and discards any partial count.
- R6: While `mask_mode_i` is 1 and `ri_i` is 0, no new request is raised and the sources stay pending in `brk_cause_o`. The request rises at the first clock edge at which `ri_i` is 1.
- R7: While `mask_mode_i` is 0, a source raises the request at the next clock edge whatever the value of `ri_i`.
- R8: Out of reset, `brk_req_o` and `brk_cause_o` are zero. Once raised, `brk_req_o` stays 1 until `brk_ack_i` is seen, even if `ri_i` falls. While the request is 1, at least one cause bit is set.
- R9: The cause bits are: bit i for watchpoint i (bits 3..0), bit 4 for the on-chip peripheral line, bit 5 for the off-chip peripheral line and bit 6 for the debug-tool line. Each external line raises the request with its own bit, and simultaneous sources set all their bits.
- R10: An acknowledge clears the pending causes and the request. A source that arrives in the same cycle as the acknowledge is kept as the only cause, and it raises the request again at that edge when recognition is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_hit_i | input | 4 | Watchpoint hit pulses from the comparators |
| wp_pin_o | output | 4 | Registered watchpoint report pins |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Watchpoint selected by the write |
| cfg_sw_en_i | input | 1 | Software trap enable value to write |
| cfg_dp_en_i | input | 1 | Development-port trap enable value to write |
| cfg_count_i | input | 16 | Occurrence count value to write |
| ext_onchip_i | input | 1 | Breakpoint request from an on-chip peripheral |
| ext_offchip_i | input | 1 | Breakpoint request from an off-chip peripheral |
| ext_tool_i | input | 1 | Breakpoint request from the external debug tool |
| ri_i | input | 1 | Machine state is restartable |
| mask_mode_i | input | 1 | 1: recognition gated by `ri_i`; 0: ungated |
| brk_ack_i | input | 1 | Acknowledge from the exception logic |
| brk_req_o | output | 1 | Breakpoint request level |
| brk_cause_o | output | 7 | Pending breakpoint sources |

## Verification
The situation hardest to reach from the ports is an acknowledge that lands in the same edge as a fresh source. The bench first leaves a watchpoint breakpoint waiting unacknowledged, then pulses the acknowledge and an external line in one cycle and checks that only the new cause remains. The count reload is also only visible over long hit runs. The bench therefore counts out two full periods, and it rewrites the configuration in the middle of a period to show that the partial count is lost.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

    localparam int unsigned WP_COUNT  = 4;
    localparam int unsigned OCC_W     = 16;
    localparam int unsigned EXT_COUNT = 3;

    // position of each external line above the watchpoint cause bits
    typedef enum logic [1:0] {
        EXT_ONCHIP  = 2'd0,
        EXT_OFFCHIP = 2'd1,
        EXT_TOOL    = 2'd2
    } ext_src_e;

    typedef struct packed {
        logic             sw_trap;
        logic             dp_trap;
        logic [OCC_W-1:0] occ;
    } wp_cfg_t;

    function automatic logic wp_armed(input wp_cfg_t c);
        return c.sw_trap | c.dp_trap;
    endfunction

    // a count of 0 or 1 means every hit is the final one
    function automatic logic occ_final(input logic [OCC_W-1:0] remaining);
        return remaining <= OCC_W'(1);
    endfunction

endpackage

// File: rtl/dbg_wp_channel.sv
module dbg_wp_channel
    import dbg_brk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_i,
    input  wp_cfg_t wr_cfg_i,
    input  logic    hit_i,
    output logic    fire_o,
    output logic    pin_o
);

    wp_cfg_t          cfg_q;
    logic [OCC_W-1:0] remain_q;
    logic             counts;

    // a write in the same cycle as a hit takes precedence
    assign counts = hit_i & wp_armed(cfg_q) & ~wr_i;
    assign fire_o = counts & occ_final(remain_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            remain_q <= '0;
            pin_o    <= 1'b0;
        end else begin
            pin_o <= hit_i;
            if (wr_i) begin
                cfg_q    <= wr_cfg_i;
                remain_q <= wr_cfg_i.occ;
            end else if (counts) begin
                remain_q <= occ_final(remain_q) ? cfg_q.occ : remain_q - OCC_W'(1);
            end
        end
    end

    AST_PIN_MIRROR: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pin_o == $past(hit_i)))
        else $error("pin mismatch"); // R1

    AST_REMAIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        remain_q <= cfg_q.occ)
        else $error("remaining count above programmed count"); // R4

endmodule

// File: rtl/dbg_brk_collect.sv
module dbg_brk_collect
    import dbg_brk_pkg::*;
#(
    parameter int unsigned NUM_WP  = WP_COUNT,
    parameter int unsigned NUM_EXT = EXT_COUNT,
    localparam int unsigned NSRC   = NUM_WP + NUM_EXT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_WP-1:0]  wp_fire_i,
    input  logic [NUM_EXT-1:0] ext_i,
    input  logic               ri_i,
    input  logic               mask_mode_i,
    input  logic               ack_i,
    output logic               req_o,
    output logic [NSRC-1:0]    cause_o
);

    logic [NSRC-1:0] events;
    logic [NSRC-1:0] pend_nxt;
    logic            allow;
    logic            req_nxt;

    assign events   = {ext_i, wp_fire_i};
    assign allow    = ~mask_mode_i | ri_i;
    assign pend_nxt = ack_i ? events : (cause_o | events);
    assign req_nxt  = (|pend_nxt) & (allow | (req_o & ~ack_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_o <= '0;
            req_o   <= 1'b0;
        end else begin
            cause_o <= pend_nxt;
            req_o   <= req_nxt;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_o && !ack_i) |=> req_o)
        else $error("request dropped without acknowledge"); // R8

    AST_MASK_GATE: assert property (@(posedge clk) disable iff (rst)
        (mask_mode_i && !ri_i && !req_o) |=> !req_o)
        else $error("request raised while not restartable"); // R6

    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        req_o |-> (cause_o != '0))
        else $error("request without cause"); // R8

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        (ack_i && events == '0) |=> (!req_o && cause_o == '0))
        else $error("acknowledge did not clear"); // R10

endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit
    import dbg_brk_pkg::*;
#(
    parameter int unsigned NUM_WP  = WP_COUNT,
    localparam int unsigned SEL_W  = (NUM_WP > 1) ? $clog2(NUM_WP) : 1,
    localparam int unsigned NSRC   = NUM_WP + EXT_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_WP-1:0] wp_hit_i,
    output logic [NUM_WP-1:0] wp_pin_o,
    input  logic              cfg_wr_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    input  logic              cfg_sw_en_i,
    input  logic              cfg_dp_en_i,
    input  logic [OCC_W-1:0]  cfg_count_i,
    input  logic              ext_onchip_i,
    input  logic              ext_offchip_i,
    input  logic              ext_tool_i,
    input  logic              ri_i,
    input  logic              mask_mode_i,
    input  logic              brk_ack_i,
    output logic              brk_req_o,
    output logic [NSRC-1:0]   brk_cause_o
);

    wp_cfg_t                wr_cfg;
    logic [NUM_WP-1:0]      fire;
    logic [EXT_COUNT-1:0]   ext_vec;

    assign wr_cfg = '{sw_trap: cfg_sw_en_i, dp_trap: cfg_dp_en_i, occ: cfg_count_i};

    always_comb begin
        ext_vec              = '0;
        ext_vec[EXT_ONCHIP]  = ext_onchip_i;
        ext_vec[EXT_OFFCHIP] = ext_offchip_i;
        ext_vec[EXT_TOOL]    = ext_tool_i;
    end

    for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
        dbg_wp_channel u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_i     (cfg_wr_i && (cfg_sel_i == SEL_W'(g))),
            .wr_cfg_i (wr_cfg),
            .hit_i    (wp_hit_i[g]),
            .fire_o   (fire[g]),
            .pin_o    (wp_pin_o[g])
        );
    end

    dbg_brk_collect #(
        .NUM_WP  (NUM_WP),
        .NUM_EXT (EXT_COUNT)
    ) u_collect (
        .clk         (clk),
        .rst         (rst),
        .wp_fire_i   (fire),
        .ext_i       (ext_vec),
        .ri_i        (ri_i),
        .mask_mode_i (mask_mode_i),
        .ack_i       (brk_ack_i),
        .req_o       (brk_req_o),
        .cause_o     (brk_cause_o)
    );

endmodule

// File: tb/dbg_brk_unit_tb.sv
module dbg_brk_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  wp_hit = '0;
    logic [3:0]  wp_pin;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic        cfg_sw = 1'b0;
    logic        cfg_dp = 1'b0;
    logic [15:0] cfg_cnt = '0;
    logic        e_on = 1'b0, e_off = 1'b0, e_tool = 1'b0;
    logic        ri = 1'b1;
    logic        mask_mode = 1'b1;
    logic        ack = 1'b0;
    logic        req;
    logic [6:0]  cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dbg_brk_unit dut_i (
        .clk(clk), .rst(rst), .wp_hit_i(wp_hit), .wp_pin_o(wp_pin),
        .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_sw_en_i(cfg_sw),
        .cfg_dp_en_i(cfg_dp), .cfg_count_i(cfg_cnt),
        .ext_onchip_i(e_on), .ext_offchip_i(e_off), .ext_tool_i(e_tool),
        .ri_i(ri), .mask_mode_i(mask_mode), .brk_ack_i(ack),
        .brk_req_o(req), .brk_cause_o(cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_wp(input int idx, input logic sw, input logic dp, input int cnt);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'(idx); cfg_sw = sw; cfg_dp = dp; cfg_cnt = 16'(cnt);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // one-cycle hit pulse; returns sampled after the capturing edge
    task automatic hit(input int idx);
        wp_hit[idx] = 1'b1;
        @(negedge clk);
        wp_hit = '0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8 reset req", 32'(req), 0);
        chk("R8 reset cause", 32'(cause), 0);
        chk("R1 reset pins", 32'(wp_pin), 0);
    endtask

    task automatic t_pins();
        hit(2);
        chk("R1 pin mirror", 32'(wp_pin), 32'h4);
        chk("R1 disabled no req", 32'(req), 0);
        chk("R1 disabled no cause", 32'(cause), 0);
        @(negedge clk);
        chk("R1 pin falls", 32'(wp_pin), 0);
    endtask

    task automatic t_enables();
        write_wp(0, 1, 0, 0);
        hit(0);
        chk("R2 sw enable req", 32'(req), 1);
        chk("R9 wp0 cause", 32'(cause), 32'h01);
        do_ack();
        chk("R10 ack clears req", 32'(req), 0);
        chk("R10 ack clears cause", 32'(cause), 0);
        hit(0);
        chk("R3 count0 every hit", 32'(req), 1);
        do_ack();
        write_wp(1, 0, 1, 1);
        hit(1);
        chk("R2 dp enable req", 32'(req), 1);
        chk("R3 count1 cause wp1", 32'(cause), 32'h02);
        do_ack();
        hit(1);
        chk("R3 count1 second hit", 32'(req), 1);
        do_ack();
    endtask

    task automatic t_count();
        write_wp(3, 1, 0, 3);
        for (int p = 0; p < 2; p++) begin
            hit(3); @(negedge clk);
            chk("R4 hit1 quiet", 32'(req), 0);
            hit(3);
            chk("R4 hit2 quiet", 32'(req), 0);
            hit(3);
            chk("R4 hit3 fires", 32'(req), 1);
            chk("R4 cause wp3", 32'(cause), 32'h08);
            do_ack();
        end
    endtask

    task automatic t_rewrite();
        write_wp(3, 1, 1, 3);
        hit(3); hit(3);
        write_wp(3, 1, 1, 3);
        hit(3); hit(3);
        chk("R5 partial count discarded", 32'(req), 0);
        hit(3);
        chk("R5 fires after full count", 32'(req), 1);
        do_ack();
    endtask

    task automatic t_masked();
        mask_mode = 1'b1; ri = 1'b0;
        hit(0);
        repeat (3) @(negedge clk);
        chk("R6 held off", 32'(req), 0);
        chk("R6 cause pending", 32'(cause), 32'h01);
        ri = 1'b1;
        @(negedge clk);
        chk("R6 raised on ri", 32'(req), 1);
        ri = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 held without ack", 32'(req), 1);
        ri = 1'b1;
        do_ack();
        chk("R8 cleared by ack", 32'(req), 0);
    endtask

    task automatic t_unmasked();
        mask_mode = 1'b0; ri = 1'b0;
        hit(1);
        chk("R7 unmasked raises", 32'(req), 1);
        do_ack();
        mask_mode = 1'b1; ri = 1'b1;
    endtask

    task automatic t_ext();
        e_on = 1'b1; @(negedge clk); e_on = 1'b0;
        chk("R9 onchip req", 32'(req), 1);
        chk("R9 onchip bit4", 32'(cause), 32'h10);
        do_ack();
        e_off = 1'b1; @(negedge clk); e_off = 1'b0;
        chk("R9 offchip bit5", 32'(cause), 32'h20);
        do_ack();
        e_tool = 1'b1; wp_hit[0] = 1'b1; @(negedge clk); e_tool = 1'b0; wp_hit = '0;
        chk("R9 tool plus wp0", 32'(cause), 32'h41);
        do_ack();
    endtask

    task automatic t_collide();
        hit(0);
        chk("R10 pre req", 32'(req), 1);
        ack = 1'b1; e_off = 1'b1;
        @(negedge clk);
        ack = 1'b0; e_off = 1'b0;
        chk("R10 new source kept", 32'(cause), 32'h20);
        chk("R10 req reasserted", 32'(req), 1);
        do_ack();
        chk("R10 final clear", 32'(req), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pins();
        t_enables();
        t_count();
        t_rewrite();
        t_masked();
        t_unmasked();
        t_ext();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule